// File: doc/BRIEF.md
# Cube-Face Segment Address Generator

This block turns a cube-face sample position into six segment addresses for a display memory that is split into six independently addressed segments, A to F. The inputs are a face number (0 to 5) and a 9-bit column `i` and row `j` on that face. Segments are paired: A/B, C/D and E/F. Within a pair, at equal address, the first segment (A, C or E) holds the even column and the second (B, D or F) holds the odd column to its right. On every face, one pair stores the even rows and another pair stores the odd rows. So for any sample point, four of the six addresses land on the 2x2 neighbourhood `(i..i+1, j..j+1)`, which an interpolation filter downstream needs.

Each pair's address carries a half-step correction of the form `(x + 1) >> 1` where parity and face call for it. Sums that would leave the face saturate. Two address sets are produced for double buffering. The display set comes from the lookup pipeline and is read-only. The renderer set comes from the scan converter and carries per-segment write enables. A buffer-select input routes each set to one of two physical banks. In clear mode the renderer set drives one linear address to all six segments, with all six write enables set, so a cleared buffer takes a sixth of the cycles. The segment memories and the pixel reorder network lie outside the block. All outputs are registered.

Top module: `cube_seg_addr_gen`

## Requirements
- R1: While `rst_ni` is low, all bank addresses and write enables are zero.
- R2: Outputs change exactly one clock edge after the inputs that produce them, and hold until the next edge.
- R3: Each segment address packs three fields: bits 7:0 are the column field, bits 15:8 the row field and bits 17:16 the high field. Segment k (A=0 ... F=5) occupies bits `k*18 +: 18` of a bank bus. For a pair serving the face, the column field of B, D and F is `i >> 1`. The column field of A, C and E is `(i + 1) >> 1`, saturated at 255.
- R4: The even-row pair is AB on faces 0-1, CD on faces 2-3 and EF on faces 4-5. Its row field is `(j + 1) >> 1`, saturated at 255. The odd-row pair is CD on faces 0-1, EF on faces 2-3 and AB on faces 4-5. Its row field is `j >> 1`.
- R5: In the high field, bit 17 is 1 for the odd-row pair and 0 for the even-row pair, and bit 16 equals face bit 0. The pair that does not serve the face outputs address zero in both of its segments.
- R6: Face numbers 6 and 7 produce zero on all six addresses and no write enable.
- R7: With `buf_sel_i` at 0, bank 0 carries the display set and bank 1 the renderer set. With `buf_sel_i` at 1 the two are swapped.
- R8: The bank that carries the display set has all write enables at zero.
- R9: When `ren_wr_i` is high and clear mode is off, exactly one renderer write enable is set. Bit k corresponds to segment k. Even `j` selects the even-row pair and odd `j` the odd-row pair. Even `i` selects the first segment of that pair and odd `i` the second. When `ren_wr_i` is low, no write enable is set.
- R10: While `clr_i` is high, all six renderer addresses equal `clr_addr_i`. If `ren_wr_i` is also high, all six renderer write enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_face_i | input | 3 | Display sample face number |
| disp_i_i | input | 9 | Display sample column |
| disp_j_i | input | 9 | Display sample row |
| ren_face_i | input | 3 | Renderer pixel face number |
| ren_i_i | input | 9 | Renderer pixel column |
| ren_j_i | input | 9 | Renderer pixel row |
| ren_wr_i | input | 1 | Renderer write request |
| clr_i | input | 1 | Clear mode: broadcast one address to all segments |
| clr_addr_i | input | 18 | Linear segment address used in clear mode |
| buf_sel_i | input | 1 | Selects which bank carries the renderer set |
| bank0_addr_o | output | 108 | Bank 0 segment addresses, segment k at bits k*18 +: 18 |
| bank0_we_o | output | 6 | Bank 0 segment write enables |
| bank1_addr_o | output | 108 | Bank 1 segment addresses |
| bank1_we_o | output | 6 | Bank 1 segment write enables |

## Verification
The assertions check several rules on every cycle. At most one write enable is set outside clear mode, and a clear write sets all six. The display bank never writes. An invalid face zeroes the display addresses. The first and second column fields of the display set never differ by more than one. The exact field values need the bench's sweeps: every face, every column and every row, with parity mixing. Those sweeps cover the saturation at 511, the placement of the high field, bank swapping, and the one-edge latency, each compared against values computed arithmetically.

// File: rtl/cube_seg_addr_pkg.sv
package cube_seg_addr_pkg;
  localparam int FACE_W = 3;
  localparam int PAIR_N = 3;
  localparam int SEG_N  = 2 * PAIR_N;
  localparam int FPAIR_W = FACE_W - 1;

  // pair that stores the odd rows of face pair fp
  function automatic int odd_pair_of(input int fp);
    return (fp + 1) % PAIR_N;
  endfunction
endpackage

// File: rtl/half_step.sv
module half_step #(
  parameter int W = 9
) (
  input  logic [W-1:0] v_i,
  output logic [W-2:0] dn_o,
  output logic [W-2:0] up_o
);
  // (v+1)>>1 == (v>>1) + v[0]; only all-ones overflows
  assign dn_o = v_i[W-1:1];
  assign up_o = (&v_i) ? '1 : v_i[W-1:1] + (W-1)'(v_i[0]);
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
  import cube_seg_addr_pkg::*;
#(
  parameter int COORD_W = 9,
  localparam int HALF_W = COORD_W - 1,
  localparam int ADDR_W = 2 * HALF_W + 2
) (
  input  logic [FACE_W-1:0]       face_i,
  input  logic [COORD_W-1:0]      i_i,
  input  logic [COORD_W-1:0]      j_i,
  output logic [SEG_N*ADDR_W-1:0] addr_o
);
  logic [HALF_W-1:0] i_dn, i_up, j_dn, j_up;
  logic [FPAIR_W-1:0] fp;
  logic               face_ok;

  half_step #(.W(COORD_W)) u_col (.v_i(i_i), .dn_o(i_dn), .up_o(i_up));
  half_step #(.W(COORD_W)) u_row (.v_i(j_i), .dn_o(j_dn), .up_o(j_up));

  assign fp      = face_i[FACE_W-1:1];
  assign face_ok = (fp < FPAIR_W'(PAIR_N));

  for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
    localparam int ODD_FP = (p + PAIR_N - 1) % PAIR_N;  // face pair whose odd rows live here
    logic              even_hit, odd_hit;
    logic [HALF_W-1:0] row;
    logic [1:0]        hi;

    assign even_hit = face_ok && (fp == FPAIR_W'(p));
    assign odd_hit  = face_ok && (fp == FPAIR_W'(ODD_FP));
    assign row      = even_hit ? j_up : j_dn;
    assign hi       = {odd_hit, face_i[0]};

    assign addr_o[(2*p)*ADDR_W +: ADDR_W]   = (even_hit || odd_hit) ? {hi, row, i_up} : '0;
    assign addr_o[(2*p+1)*ADDR_W +: ADDR_W] = (even_hit || odd_hit) ? {hi, row, i_dn} : '0;
  end
endmodule

// File: rtl/pix_seg_sel.sv
module pix_seg_sel
  import cube_seg_addr_pkg::*;
(
  input  logic [FACE_W-1:0] face_i,
  input  logic              i_lsb_i,
  input  logic              j_lsb_i,
  input  logic              wr_i,
  input  logic              clr_i,
  output logic [SEG_N-1:0]  we_o
);
  logic [FPAIR_W-1:0] fp;
  logic               face_ok;

  assign fp      = face_i[FACE_W-1:1];
  assign face_ok = (fp < FPAIR_W'(PAIR_N));

  for (genvar k = 0; k < SEG_N; k++) begin : g_seg
    localparam int PAIR  = k / 2;
    localparam int RIGHT = k % 2;
    logic even_match, odd_match;
    assign even_match = !j_lsb_i && (fp == FPAIR_W'(PAIR));
    assign odd_match  =  j_lsb_i && (fp == FPAIR_W'((PAIR + PAIR_N - 1) % PAIR_N));
    assign we_o[k] = wr_i && (clr_i ||
                     (face_ok && (even_match || odd_match) && (i_lsb_i == 1'(RIGHT))));
  end
endmodule

// File: rtl/cube_seg_addr_gen.sv
module cube_seg_addr_gen
  import cube_seg_addr_pkg::*;
#(
  parameter int COORD_W = 9,
  localparam int HALF_W = COORD_W - 1,
  localparam int ADDR_W = 2 * HALF_W + 2,
  localparam int BUS_W  = SEG_N * ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FACE_W-1:0]  disp_face_i,
  input  logic [COORD_W-1:0] disp_i_i,
  input  logic [COORD_W-1:0] disp_j_i,
  input  logic [FACE_W-1:0]  ren_face_i,
  input  logic [COORD_W-1:0] ren_i_i,
  input  logic [COORD_W-1:0] ren_j_i,
  input  logic               ren_wr_i,
  input  logic               clr_i,
  input  logic [ADDR_W-1:0]  clr_addr_i,
  input  logic               buf_sel_i,
  output logic [BUS_W-1:0]   bank0_addr_o,
  output logic [SEG_N-1:0]   bank0_we_o,
  output logic [BUS_W-1:0]   bank1_addr_o,
  output logic [SEG_N-1:0]   bank1_we_o
);
  logic [BUS_W-1:0] disp_addr, ren_calc, ren_addr;
  logic [SEG_N-1:0] ren_we;

  seg_addr_calc #(.COORD_W(COORD_W)) u_disp_calc (
    .face_i(disp_face_i), .i_i(disp_i_i), .j_i(disp_j_i), .addr_o(disp_addr)
  );

  seg_addr_calc #(.COORD_W(COORD_W)) u_ren_calc (
    .face_i(ren_face_i), .i_i(ren_i_i), .j_i(ren_j_i), .addr_o(ren_calc)
  );

  pix_seg_sel u_we (
    .face_i(ren_face_i), .i_lsb_i(ren_i_i[0]), .j_lsb_i(ren_j_i[0]),
    .wr_i(ren_wr_i), .clr_i(clr_i), .we_o(ren_we)
  );

  assign ren_addr = clr_i ? {SEG_N{clr_addr_i}} : ren_calc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank0_addr_o <= '0;
      bank1_addr_o <= '0;
      bank0_we_o   <= '0;
      bank1_we_o   <= '0;
    end else if (buf_sel_i) begin
      bank0_addr_o <= ren_addr;
      bank0_we_o   <= ren_we;
      bank1_addr_o <= disp_addr;
      bank1_we_o   <= '0;
    end else begin
      bank0_addr_o <= disp_addr;
      bank0_we_o   <= '0;
      bank1_addr_o <= ren_addr;
      bank1_we_o   <= ren_we;
    end
  end

  logic [HALF_W-1:0] col_gap;
  assign col_gap = disp_addr[0 +: HALF_W] - disp_addr[ADDR_W +: HALF_W];

  AST_COL_ADJACENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_gap <= HALF_W'(1)); // R3

  AST_SINGLE_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> $onehot0(bank0_we_o | bank1_we_o)); // R9

  AST_CLEAR_ALL_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ren_wr_i) |=> ((bank0_we_o | bank1_we_o) == '1)); // R10

  AST_DISP_BANK0_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_sel_i |=> (bank0_we_o == '0)); // R8

  AST_DISP_BANK1_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_sel_i |=> (bank1_we_o == '0)); // R8

  AST_BAD_FACE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_face_i > 3'd5 && !buf_sel_i) |=> (bank0_addr_o == '0)); // R6
endmodule

// File: tb/cube_seg_addr_gen_tb_top.sv
module cube_seg_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int BW = 6 * AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    disp_face, ren_face;
  logic [8:0]    disp_i, disp_j, ren_i, ren_j;
  logic          ren_wr, clr, buf_sel;
  logic [AW-1:0] clr_addr;
  logic [BW-1:0] b0_addr, b1_addr;
  logic [5:0]    b0_we, b1_we;
  int            n_run = 0;
  int            n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cube_seg_addr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_face_i(disp_face), .disp_i_i(disp_i), .disp_j_i(disp_j),
    .ren_face_i(ren_face), .ren_i_i(ren_i), .ren_j_i(ren_j),
    .ren_wr_i(ren_wr), .clr_i(clr), .clr_addr_i(clr_addr), .buf_sel_i(buf_sel),
    .bank0_addr_o(b0_addr), .bank0_we_o(b0_we),
    .bank1_addr_o(b1_addr), .bank1_we_o(b1_we)
  );

  function automatic int min255(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  function automatic logic [AW-1:0] exp_seg(input int f, input int i, input int j, input int seg);
    int fp, pair, col, row, hi;
    if (f > 5) return '0;
    fp   = f / 2;
    pair = seg / 2;
    col  = (seg % 2 == 0) ? min255((i + 1) / 2) : i / 2;
    if (pair == fp) begin
      row = min255((j + 1) / 2); hi = 0;
    end else if (pair == (fp + 1) % 3) begin
      row = j / 2; hi = 2;
    end else return '0;
    hi = hi + f % 2;
    return AW'(hi * 65536 + row * 256 + col);
  endfunction

  function automatic logic [BW-1:0] exp_bus(input int f, input int i, input int j,
                                            input bit c, input logic [AW-1:0] ca);
    logic [BW-1:0] r;
    for (int s = 0; s < 6; s++) r[s*AW +: AW] = c ? ca : exp_seg(f, i, j, s);
    return r;
  endfunction

  function automatic logic [5:0] exp_we(input int f, input int i, input int j,
                                        input bit wr, input bit c);
    int fp, pair;
    if (!wr) return '0;
    if (c) return '1;
    if (f > 5) return '0;
    fp   = f / 2;
    pair = (j % 2 == 1) ? (fp + 1) % 3 : fp;
    return 6'(1 << (pair * 2 + i % 2));
  endfunction

  task automatic chk_bus(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_we(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s we act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic apply(input int df, input int di, input int dj,
                       input int rf, input int ri, input int rj,
                       input bit wr, input bit c, input logic [AW-1:0] ca,
                       input bit sel, input string tag_a, input string tag_w);
    logic [BW-1:0] ed, er;
    logic [5:0]    ew;
    @(negedge clk);
    disp_face = 3'(df); disp_i = 9'(di); disp_j = 9'(dj);
    ren_face = 3'(rf); ren_i = 9'(ri); ren_j = 9'(rj);
    ren_wr = wr; clr = c; clr_addr = ca; buf_sel = sel;
    @(posedge clk); #1;
    ed = exp_bus(df, di, dj, 1'b0, '0);
    er = exp_bus(rf, ri, rj, c, ca);
    ew = exp_we(rf, ri, rj, wr, c);
    if (sel) begin
      chk_bus(tag_a, b1_addr, ed); chk_bus(tag_a, b0_addr, er);
      chk_we("R8", b1_we, '0);     chk_we(tag_w, b0_we, ew);
    end else begin
      chk_bus(tag_a, b0_addr, ed); chk_bus(tag_a, b1_addr, er);
      chk_we("R8", b0_we, '0);     chk_we(tag_w, b1_we, ew);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    disp_face = 3'd1; disp_i = 9'd77; disp_j = 9'd33;
    ren_face = 3'd2; ren_i = 9'd5; ren_j = 9'd9;
    ren_wr = 1'b1; clr = 1'b0; clr_addr = '0; buf_sel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset holds outputs at zero
    chk_bus("R1", b0_addr, '0); chk_bus("R1", b1_addr, '0);
    chk_we("R1", b0_we, '0);    chk_we("R1", b1_we, '0);
    @(negedge clk); rst_ni = 1'b1;

    // R2: latency of one edge
    apply(0, 10, 20, 3, 4, 5, 1'b1, 1'b0, '0, 1'b0, "R2", "R9");
    @(negedge clk);
    disp_face = 3'd5; disp_i = 9'd300; disp_j = 9'd301;
    #1;
    chk_bus("R2", b0_addr, exp_bus(0, 10, 20, 1'b0, '0));
    @(posedge clk); #1;
    chk_bus("R2", b0_addr, exp_bus(5, 300, 301, 1'b0, '0));

    // R3: column sweep on every face
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 512; i++)
        apply(f, i, (i * 7 + f) % 512, f, 511 - i, (i * 3 + f) % 512,
              1'b1, 1'b0, '0, 1'(i % 2), "R3", "R9");

    // R4: row sweep on every face
    for (int f = 0; f < 8; f++)
      for (int j = 0; j < 512; j++)
        apply(f, (j * 5) % 512, j, (f + 3) % 8, (j * 11) % 512, 511 - j,
              1'b1, 1'b0, '0, 1'((j / 2) % 2), "R4", "R9");

    // R5 / R6: corner coordinates, all faces
    for (int f = 0; f < 8; f++)
      for (int c = 0; c < 16; c++) begin
        int ci, cj;
        ci = (c % 4 < 2) ? c % 4 : 508 + c % 4;
        cj = (c / 4 < 2) ? c / 4 : 508 + c / 4;
        apply(f, ci, cj, f, cj, ci, 1'b1, 1'b0, '0, 1'(c % 2),
              (f > 5) ? "R6" : "R5", (f > 5) ? "R6" : "R9");
      end

    // R7: bank swap with fixed inputs
    for (int n = 0; n < 16; n++)
      apply(n % 6, 100 + n, 200 + n, (n + 2) % 6, 50 + n, 60 + n,
            1'b1, 1'b0, '0, 1'(n % 2), "R7", "R9");

    // R9: no write request, no enable
    for (int n = 0; n < 12; n++)
      apply(n % 6, n, n, n % 6, n * 3, n * 5, 1'b0, 1'b0, '0, 1'(n % 2), "R9", "R9");

    // R10: clear mode broadcast, with and without write
    for (int n = 0; n < 24; n++)
      apply(n % 8, n * 21, n * 13, n % 8, n * 9, n * 17, 1'(n % 3 != 0), 1'b1,
            AW'(n * 10007 + 3), 1'(n % 2), "R10", "R10");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule